// File: doc/BRIEF.md
# Two-Slot Recent Translation Cache

This block sits in front of a full translation lookup. It holds the two entries most recently used for data accesses, so a run of accesses to the same pages skips the full search. Each slot keeps an entry identifier, a base virtual address, an offset mask (page size minus one), a physical page address and an access-space code. A request gives a virtual address, an access size in bytes and an access-space code. One clock later the block answers with a hit and the physical address, or with a miss.

On a miss, the surrounding logic runs the full lookup and returns the entry through the fill port. A fill of an entry not already held pushes slot 0 into slot 1 and writes the new entry into slot 0. The cache as a whole is valid only for the context state it recorded at the last fill. Any insert, demap or invalidate in the backing table drops it, and so does a change in context state.

Top module: `xlat_recent_cache`

## Requirements
- R1: After reset `rsp_valid` and `rsp_hit` are 0 and the cache is empty, so the first request misses.
- R2: Every cycle with `req_valid` high is answered in the next cycle with `rsp_valid` high and exactly one of `rsp_hit` or `rsp_miss` high. A cycle without a request is followed by `rsp_valid` low.
- R3: A slot's range matches only if slot_va < req_va + req_size and slot_va + slot_mask > req_va. Both use unsigned arithmetic without wrap, and the upper bound is strict.
- R4: A slot matches only if its stored code equals the request's effective code. The effective code is `req_asi`, or 0 when `req_implicit` is high.
- R5: No slot hits unless the context state recorded at the last fill equals the present `ctx_state`.
- R6: On a hit, `rsp_paddr` = (slot_pa AND NOT slot_mask) OR (req_va AND slot_mask).
- R7: When both slots match, the address comes from slot 0.
- R8: A fill whose `fill_id` is held by neither occupied slot moves slot 0 into slot 1 and writes the new entry into slot 0. Its code is `fill_asi`, or 0 when `fill_implicit` is high. The previous slot 1 is dropped.
- R9: A fill whose `fill_id` equals an occupied slot's identifier while the cache is valid leaves both slots unchanged.
- R10: A fill into an invalid cache first empties both slots, so only the new entry can hit afterwards.
- R11: A `tlb_modify` pulse makes the cache invalid, so all later requests miss until the next fill. A fill in the same cycle as `tlb_modify` is dropped.
- R12: A fill makes the cache valid and records the present `ctx_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_state | input | CTX_W | Present translation context state |
| tlb_modify | input | 1 | Backing table insert, demap or invalidate |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Request virtual address |
| req_size | input | SIZE_W | Access size in bytes |
| req_asi | input | ASI_W | Request access-space code |
| req_implicit | input | 1 | Implicit access (code taken as 0) |
| fill_valid | input | 1 | Refill from full lookup |
| fill_id | input | ID_W | Entry identifier |
| fill_va | input | VA_W | Entry base virtual address |
| fill_mask | input | VA_W | Entry offset mask |
| fill_pa | input | PA_W | Entry physical address |
| fill_asi | input | ASI_W | Access-space code of the missed request |
| fill_implicit | input | 1 | Store code 0 |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_paddr | output | PA_W | Translated address on a hit |

## Verification
The bench goes after the range edges:
- the last byte of a page, which must miss under the strict bound;
- an access that ends exactly at the entry base;
- an access that starts below the base and straddles into the page.

An off-by-one compare would turn those misses into hits or the straddle into a miss. It also fills so that both slots cover one address, which catches a design with the wrong priority. It refills an entry that is already held, which catches a design that shifts on every fill and loses the older entry. It fills right after an invalidate and in the same cycle as one, which exposes stale slots or a valid flag set when it should be dropped. A context change between fill and lookup exposes a design that ignores the recorded state.

// File: rtl/xlat_recent_cache.sv
module xlat_recent_cache #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 20,
  parameter int ASI_W  = 8,
  parameter int SIZE_W = 4,
  parameter int CTX_W  = 8,
  parameter int ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_W-1:0]  ctx_state,
  input  logic              tlb_modify,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ASI_W-1:0]  req_asi,
  input  logic              req_implicit,
  input  logic              fill_valid,
  input  logic [ID_W-1:0]   fill_id,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [VA_W-1:0]   fill_mask,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [ASI_W-1:0]  fill_asi,
  input  logic              fill_implicit,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_paddr
);
  localparam int EXT_W = VA_W + 1;
  localparam int NSLOT = 2;

  logic              cache_vld;
  logic [CTX_W-1:0]  ctx_q;
  logic              s_occ  [NSLOT];
  logic [ID_W-1:0]   s_id   [NSLOT];
  logic [VA_W-1:0]   s_va   [NSLOT];
  logic [VA_W-1:0]   s_mask [NSLOT];
  logic [PA_W-1:0]   s_pa   [NSLOT];
  logic [ASI_W-1:0]  s_asi  [NSLOT];

  logic [NSLOT-1:0]  slot_hit;
  logic [NSLOT-1:0]  slot_known;
  logic [PA_W-1:0]   slot_pa [NSLOT];

  wire [ASI_W-1:0] req_code  = req_implicit  ? '0 : req_asi;
  wire [ASI_W-1:0] fill_code = fill_implicit ? '0 : fill_asi;
  wire             ctx_ok    = cache_vld && (ctx_q == ctx_state);
  wire [EXT_W-1:0] req_lo    = EXT_W'(req_va);
  wire [EXT_W-1:0] req_end   = EXT_W'(req_va) + EXT_W'(req_size);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wire [EXT_W-1:0] ent_lo  = EXT_W'(s_va[g]);
    wire [EXT_W-1:0] ent_end = EXT_W'(s_va[g]) + EXT_W'(s_mask[g]);
    assign slot_hit[g]   = ctx_ok && s_occ[g] && (s_asi[g] == req_code) &&
                           (ent_lo < req_end) && (ent_end > req_lo);
    assign slot_pa[g]    = (s_pa[g] & ~PA_W'(s_mask[g])) |
                           PA_W'(req_va & s_mask[g]);
    assign slot_known[g] = cache_vld && s_occ[g] && (s_id[g] == fill_id);
  end

  assign rsp_miss = rsp_valid & ~rsp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      cache_vld <= 1'b0;
      ctx_q     <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        s_occ[i]  <= 1'b0;
        s_id[i]   <= '0;
        s_va[i]   <= '0;
        s_mask[i] <= '0;
        s_pa[i]   <= '0;
        s_asi[i]  <= '0;
      end
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && (|slot_hit);
      rsp_paddr <= slot_hit[0] ? slot_pa[0] : (slot_hit[1] ? slot_pa[1] : '0);
      if (tlb_modify) begin
        cache_vld <= 1'b0;
      end else if (fill_valid) begin
        cache_vld <= 1'b1;
        ctx_q     <= ctx_state;
        if (slot_known == '0) begin
          s_occ[1]  <= cache_vld && s_occ[0];
          s_id[1]   <= s_id[0];
          s_va[1]   <= s_va[0];
          s_mask[1] <= s_mask[0];
          s_pa[1]   <= s_pa[0];
          s_asi[1]  <= s_asi[0];
          s_occ[0]  <= 1'b1;
          s_id[0]   <= fill_id;
          s_va[0]   <= fill_va;
          s_mask[0] <= fill_mask;
          s_pa[0]   <= fill_pa;
          s_asi[0]  <= fill_code;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_recent_cache_chk.sv
module xlat_recent_cache_chk #(
  parameter int CTX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             tlb_modify,
  input logic             fill_valid,
  input logic             cache_vld,
  input logic [CTX_W-1:0] ctx_q,
  input logic [CTX_W-1:0] ctx_state
);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1
  hit_needs_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  // R11
  modify_drops_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_modify |=> !cache_vld);
  // R12
  fill_records_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !tlb_modify) |=> (cache_vld && ctx_q == $past(ctx_state)));
  // R5
  hit_needs_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (ctx_q != ctx_state)) |=> !rsp_hit);
endmodule

bind xlat_recent_cache xlat_recent_cache_chk #(.CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .tlb_modify(tlb_modify), .fill_valid(fill_valid),
  .cache_vld(cache_vld), .ctx_q(ctx_q), .ctx_state(ctx_state)
);

// File: tb/test_xlat_recent_cache.sv
`timescale 1ns/1ps
module test_xlat_recent_cache;
  localparam int VA_W = 16, PA_W = 20, ASI_W = 8, SIZE_W = 4, CTX_W = 8, ID_W = 6;

  logic clk = 0, rst_n = 0;
  logic [CTX_W-1:0] ctx_state = 1;
  logic tlb_modify = 0, req_valid = 0, req_implicit = 0, fill_valid = 0, fill_implicit = 0;
  logic [VA_W-1:0] req_va = 0, fill_va = 0, fill_mask = 0;
  logic [SIZE_W-1:0] req_size = 1;
  logic [ASI_W-1:0] req_asi = 0, fill_asi = 0;
  logic [ID_W-1:0] fill_id = 0;
  logic [PA_W-1:0] fill_pa = 0;
  logic rsp_valid, rsp_hit, rsp_miss;
  logic [PA_W-1:0] rsp_paddr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_recent_cache i_xlat_recent_cache (.*);

  bit m_vld; logic [CTX_W-1:0] m_ctx;
  bit m_occ[2]; logic [ID_W-1:0] m_id[2]; logic [VA_W-1:0] m_va[2], m_mask[2];
  logic [PA_W-1:0] m_pa[2]; logic [ASI_W-1:0] m_asi[2];

  function automatic bit m_match(int s);
    logic [ASI_W-1:0] code = req_implicit ? '0 : req_asi;
    longint lo = m_va[s], hi = longint'(m_va[s]) + m_mask[s];
    return m_vld && m_ctx == ctx_state && m_occ[s] && m_asi[s] == code &&
           lo < longint'(req_va) + req_size && hi > longint'(req_va);
  endfunction

  function automatic logic [PA_W-1:0] m_xlat(int s);
    logic [PA_W-1:0] mk = {{(PA_W-VA_W){1'b0}}, m_mask[s]};
    return (m_pa[s] & ~mk) | ({{(PA_W-VA_W){1'b0}}, req_va} & mk);
  endfunction

  task automatic check(string tag, logic [PA_W-1:0] act, logic [PA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit eh; logic [PA_W-1:0] ep; bit known;
    eh = 0; ep = '0;
    if (m_match(0)) begin eh = 1; ep = m_xlat(0); end
    else if (m_match(1)) begin eh = 1; ep = m_xlat(1); end
    if (tlb_modify) m_vld = 0;
    else if (fill_valid) begin
      if (!m_vld) begin m_occ[0] = 0; m_occ[1] = 0; end
      known = (m_occ[0] && m_id[0] == fill_id) || (m_occ[1] && m_id[1] == fill_id);
      if (!known) begin
        m_occ[1] = m_occ[0]; m_id[1] = m_id[0]; m_va[1] = m_va[0];
        m_mask[1] = m_mask[0]; m_pa[1] = m_pa[0]; m_asi[1] = m_asi[0];
        m_occ[0] = 1; m_id[0] = fill_id; m_va[0] = fill_va; m_mask[0] = fill_mask;
        m_pa[0] = fill_pa; m_asi[0] = fill_implicit ? '0 : fill_asi;
      end
      m_vld = 1; m_ctx = ctx_state;
    end
    @(negedge clk);
    if (req_valid) begin
      check({tag, " R2 valid"}, PA_W'(rsp_valid), 1);
      check({tag, " R2 miss"}, PA_W'(rsp_miss), PA_W'(!eh));
      check({tag, " hit"}, PA_W'(rsp_hit), PA_W'(eh));
      if (eh) check({tag, " R6 paddr"}, rsp_paddr, ep);
    end else check({tag, " R2 idle"}, PA_W'(rsp_valid), 0);
    req_valid = 0; fill_valid = 0; tlb_modify = 0;
  endtask

  task automatic do_req(logic [VA_W-1:0] va, int sz, logic [ASI_W-1:0] asi, bit imp, string tag);
    req_valid = 1; req_va = va; req_size = SIZE_W'(sz); req_asi = asi; req_implicit = imp;
    tick(tag);
  endtask

  task automatic do_fill(int id, logic [VA_W-1:0] va, logic [VA_W-1:0] mk,
                         logic [PA_W-1:0] pa, logic [ASI_W-1:0] asi, bit imp);
    fill_valid = 1; fill_id = ID_W'(id); fill_va = va; fill_mask = mk;
    fill_pa = pa; fill_asi = asi; fill_implicit = imp;
    tick("fill");
  endtask

  initial begin
    m_vld = 0; m_ctx = 0; m_occ[0] = 0; m_occ[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", PA_W'(rsp_valid), 0);
    check("R1 reset rsp_hit", PA_W'(rsp_hit), 0);
    rst_n = 1;
    do_req(16'h1234, 4, 8'h80, 0, "R1 empty");
    do_fill(1, 16'h1000, 16'h0FFF, 20'hAB000, 8'h80, 0);
    do_req(16'h1234, 4, 8'h80, 0, "R6 basic");
    check("R6 value", rsp_paddr, 20'hAB234);
    do_req(16'h1FFF, 1, 8'h80, 0, "R3 top byte");
    check("R3 strict upper", PA_W'(rsp_hit), 0);
    do_req(16'h1FFE, 1, 8'h80, 0, "R3 below top");
    do_req(16'h0FFC, 8, 8'h80, 0, "R3 straddle");
    do_req(16'h0FF8, 8, 8'h80, 0, "R3 ends at base");
    do_req(16'h1234, 4, 8'h81, 0, "R4 code mismatch");
    ctx_state = 2;
    do_req(16'h1234, 4, 8'h80, 0, "R5 ctx changed");
    check("R5 miss", PA_W'(rsp_miss), 1);
    ctx_state = 1;
    do_req(16'h1234, 4, 8'h80, 0, "R5 ctx restored");
    do_fill(2, 16'h1000, 16'h00FF, 20'h55000, 8'h80, 0);
    do_req(16'h1010, 2, 8'h80, 0, "R7 both match");
    check("R7 slot0 wins", rsp_paddr, 20'h55010);
    do_fill(3, 16'h4000, 16'h000F, 20'h77770, 8'h80, 1);
    do_req(16'h1800, 2, 8'h80, 0, "R8 oldest dropped");
    do_req(16'h4004, 2, 8'h33, 1, "R4 implicit");
    check("R4 implicit hit", rsp_paddr, 20'h77774);
    do_req(16'h1010, 2, 8'h80, 0, "R8 shifted to slot1");
    do_fill(2, 16'h1000, 16'h00FF, 20'h99000, 8'h80, 0);
    do_req(16'h1010, 2, 8'h80, 0, "R9 known refill");
    check("R9 unchanged", rsp_paddr, 20'h55010);
    tlb_modify = 1; tick("modify");
    do_req(16'h1010, 2, 8'h80, 0, "R11 after modify");
    tlb_modify = 1; fill_valid = 1; fill_id = 5; fill_va = 16'h6000; fill_mask = 16'hFF;
    fill_pa = 20'h60000; fill_asi = 8'h80; fill_implicit = 0; tick("modify+fill");
    do_req(16'h6010, 2, 8'h80, 0, "R11 fill dropped");
    check("R11 miss", PA_W'(rsp_miss), 1);
    ctx_state = 2;
    do_fill(2, 16'h2000, 16'h00FF, 20'h12300, 8'h01, 0);
    do_req(16'h1010, 2, 8'h80, 0, "R10 old slot cleared");
    do_req(16'h4004, 2, 8'h00, 1, "R10 old slot1 cleared");
    do_req(16'h2010, 2, 8'h01, 0, "R12 new ctx hit");
    check("R12 hit", PA_W'(rsp_hit), 1);
    ctx_state = 1;
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 8) ctx_state = CTX_W'($urandom_range(1, 2));
      if ($urandom_range(0, 99) < 4) tlb_modify = 1;
      if ($urandom_range(0, 99) < 25) begin
        int sh = 4 * $urandom_range(1, 3);
        fill_valid = 1; fill_id = ID_W'($urandom_range(0, 7));
        fill_mask = VA_W'((1 << sh) - 1);
        fill_va = VA_W'($urandom_range(0, 7) << 12) & ~fill_mask;
        fill_pa = PA_W'($urandom) & ~PA_W'(fill_mask);
        fill_asi = ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h01;
        fill_implicit = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 99) < 70) begin
        req_valid = 1;
        req_va = VA_W'(($urandom_range(0, 7) << 12) + $urandom_range(0, 300) - 8);
        req_size = SIZE_W'($urandom_range(1, 8));
        req_asi = ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h01;
        req_implicit = ($urandom_range(0, 3) == 0);
      end
      tick("R3 R4 R8 random");
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule